// File: doc/BRIEF.md
# Trimmable Nanosecond Time Counter

This block keeps a nanosecond time value for precision time protocol timestamping. On each reference clock in which it is running, it adds a programmable step to its counter. The step is normally the nominal clock period in nanoseconds. A correction scheme lets software trim the rate in fine steps. Once every N running clocks, the normal step is replaced by a separate correction step. With a correction step one nanosecond above or below the normal step, the block runs slightly fast or slightly slow.

The counter can wrap at a programmable period boundary rather than at the natural rollover of its width. For example, a period of 2^31 turns a 32-bit register into a 31-bit nanosecond counter, which wraps a little more than every two seconds. Each wrap can raise a one-cycle pulse. Software sees five word registers through a simple write strobe and a combinational read port. It can load the counter directly. It can also capture the live value into a holding register and read it back later.

Top module: `ptp_ns_timer`

## Requirements
- R1: After reset, every register reads zero, the counter is zero and `wrap_pulse_o` is low.
- R2: While control bit 0 is set, the counter adds the normal step (increment register bits 6:0) on every clock. While it is clear, the counter holds its value.
- R3: When the correction interval register holds a nonzero value P, every (P+1)-th running clock adds the correction step (increment register bits 14:8) instead of the normal step. Only running clocks advance the correction phase. Writing the correction interval register restarts the phase.
- R4: A correction interval of zero disables correction, so every running clock adds the normal step.
- R5: When the control period-reset field (bits 5:4) is nonzero and the period register is nonzero, a sum that reaches or passes the period becomes sum minus period. A sum exactly equal to the period therefore gives zero.
- R6: When the period-reset field is zero, the period register is ignored and the counter wraps modulo 2^32.
- R7: `wrap_pulse_o` is high for the one cycle that follows each period wrap, but only while control bit 7 is set. With bit 7 clear it stays low.
- R8: A control write with bit 11 set copies the live counter into the capture register, which the timer address reads. Bit 11 reads back as zero, and the captured value does not change until the next capture.
- R9: A write to the timer address loads the written value into the counter. This load takes priority over the increment of that clock.
- R10: The register addresses are 0 control, 1 timer, 2 period, 3 correction interval and 4 increment. Control reads back only bits 0, 4, 5 and 7, increment reads back only bits 14:8 and 6:0, and period and correction interval read back all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register, combinational |
| wrap_pulse_o | output | 1 | One-cycle pulse after a period wrap |

## Verification
The bench places the correction step at exact positions in a run. It checks that a phase which stops on a paused counter resumes in the right place; a design that counted idle clocks, or that treated the interval as N rather than N plus one, would end at a different total. Several wrap cases are covered: a sum landing exactly on the period, where a strict greater-than compare would move the pulse one cycle late; the pulse with the event bit cleared; and the period ignored when period reset is off. The bench also exercises a load written into a running counter, which exposes a design that lets the increment win over the load. Finally, it checks that the captured value stays fixed across later loads until a fresh capture.

// File: rtl/ptp_tmr_pkg.sv
package ptp_tmr_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_TIMER  = 3'd1,
    A_PERIOD = 3'd2,
    A_CORR   = 3'd3,
    A_INC    = 3'd4
  } reg_sel_e;

  localparam int CTL_RUN     = 0;
  localparam int CTL_PRST_LO = 4;
  localparam int CTL_PRST_HI = 5;
  localparam int CTL_EVT     = 7;
  localparam int CTL_CAP     = 11;
  localparam int INC_CORR_LSB = 8;
endpackage

// File: rtl/ptp_tmr_regs.sv
module ptp_tmr_regs
  import ptp_tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7,
  parameter int CPER_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  input  logic [CNT_W-1:0]    live_i,
  output logic [REG_W-1:0]    rdata_o,
  output logic                run_o,
  output logic                prst_o,
  output logic                evt_o,
  output logic [CNT_W-1:0]    period_o,
  output logic [CPER_W-1:0]   corr_per_o,
  output logic [STEP_W-1:0]   inc_norm_o,
  output logic [STEP_W-1:0]   inc_corr_o,
  output logic                load_o,
  output logic [CNT_W-1:0]    load_val_o,
  output logic                corr_restart_o
);
  logic              run_q, evt_q;
  logic [1:0]        prst_q;
  logic [CNT_W-1:0]  period_q, cap_q;
  logic [CPER_W-1:0] corr_per_q;
  logic [STEP_W-1:0] inc_norm_q, inc_corr_q;
  logic wr_ctrl, wr_per, wr_corr, wr_inc, cap_req;

  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_per  = we_i && (addr_i == A_PERIOD);
  assign wr_corr = we_i && (addr_i == A_CORR);
  assign wr_inc  = we_i && (addr_i == A_INC);
  assign cap_req = wr_ctrl && wdata_i[CTL_CAP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      evt_q      <= 1'b0;
      prst_q     <= '0;
      period_q   <= '0;
      cap_q      <= '0;
      corr_per_q <= '0;
      inc_norm_q <= '0;
      inc_corr_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= wdata_i[CTL_RUN];
        evt_q  <= wdata_i[CTL_EVT];
        prst_q <= wdata_i[CTL_PRST_HI:CTL_PRST_LO];
      end
      if (cap_req) cap_q <= live_i;
      if (wr_per)  period_q <= wdata_i[CNT_W-1:0];
      if (wr_corr) corr_per_q <= wdata_i[CPER_W-1:0];
      if (wr_inc) begin
        inc_norm_q <= wdata_i[STEP_W-1:0];
        inc_corr_q <= wdata_i[INC_CORR_LSB +: STEP_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[CTL_RUN] = run_q;
        rdata_o[CTL_EVT] = evt_q;
        rdata_o[CTL_PRST_HI:CTL_PRST_LO] = prst_q;
      end
      A_TIMER:  rdata_o[CNT_W-1:0]  = cap_q;
      A_PERIOD: rdata_o[CNT_W-1:0]  = period_q;
      A_CORR:   rdata_o[CPER_W-1:0] = corr_per_q;
      A_INC: begin
        rdata_o[STEP_W-1:0] = inc_norm_q;
        rdata_o[INC_CORR_LSB +: STEP_W] = inc_corr_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign run_o          = run_q;
  assign prst_o         = |prst_q;
  assign evt_o          = evt_q;
  assign period_o       = period_q;
  assign corr_per_o     = corr_per_q;
  assign inc_norm_o     = inc_norm_q;
  assign inc_corr_o     = inc_corr_q;
  assign load_o         = we_i && (addr_i == A_TIMER);
  assign load_val_o     = wdata_i[CNT_W-1:0];
  assign corr_restart_o = wr_corr;

  // R8: capture holds between requests
  assert_cap_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_req |=> $stable(cap_q));
endmodule

// File: rtl/ptp_tmr_corr.sv
module ptp_tmr_corr #(
  parameter int CPER_W = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [CPER_W-1:0] per_i,
  input  logic [STEP_W-1:0] inc_norm_i,
  input  logic [STEP_W-1:0] inc_corr_i,
  output logic [STEP_W-1:0] step_o
);
  logic [CPER_W-1:0] ph_q;
  logic active, hit;

  assign active = (per_i != '0);
  assign hit    = active && (ph_q == per_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ph_q <= '0;
    else if (restart_i) ph_q <= '0;
    else if (run_i && active) ph_q <= hit ? '0 : ph_q + 1'b1;
  end

  assign step_o = hit ? inc_corr_i : inc_norm_i;

  // R3: phase never passes the programmed interval
  assert_phase_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= per_i);
endmodule

// File: rtl/ptp_tmr_count.sv
module ptp_tmr_count #(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              prst_i,
  input  logic              evt_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_pulse_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, nxt;
  logic [SUM_W-1:0] sum, per_ext;
  logic             wrap_hit, pulse_q;

  assign per_ext  = {1'b0, period_i};
  assign sum      = {1'b0, cnt_q} + {{(SUM_W-STEP_W){1'b0}}, step_i};
  assign wrap_hit = prst_i && (period_i != '0) && (sum >= per_ext);

  always_comb begin
    if (wrap_hit) nxt = sum[CNT_W-1:0] - period_i;
    else          nxt = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_val_i;
      pulse_q <= 1'b0;
    end else if (run_i) begin
      cnt_q   <= nxt;
      pulse_q <= wrap_hit && evt_i;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign cnt_o        = cnt_q;
  assign wrap_pulse_o = pulse_q;

  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i) |=> $stable(cnt_q));
  assert_load_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  assert_stay_below_period_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && prst_i && period_i != '0 && cnt_q < period_i &&
     {{(CNT_W-STEP_W){1'b0}}, step_i} < period_i) |=> cnt_q < $past(period_i));
  assert_no_pulse_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> !wrap_pulse_o);
endmodule

// File: rtl/ptp_ns_timer.sv
module ptp_ns_timer
  import ptp_tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int STEP_W = 7,
  parameter int CPER_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              wrap_pulse_o
);
  logic              run, prst, evt, load, restart;
  logic [CNT_W-1:0]  period, load_val, cnt;
  logic [CPER_W-1:0] corr_per;
  logic [STEP_W-1:0] inc_norm, inc_corr, step;

  ptp_tmr_regs #(.CNT_W(CNT_W), .STEP_W(STEP_W), .CPER_W(CPER_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .live_i(cnt), .rdata_o(reg_rdata_o),
    .run_o(run), .prst_o(prst), .evt_o(evt),
    .period_o(period), .corr_per_o(corr_per),
    .inc_norm_o(inc_norm), .inc_corr_o(inc_corr),
    .load_o(load), .load_val_o(load_val), .corr_restart_o(restart)
  );

  ptp_tmr_corr #(.CPER_W(CPER_W), .STEP_W(STEP_W)) u_corr (
    .clk_i, .rst_ni,
    .run_i(run), .restart_i(restart), .per_i(corr_per),
    .inc_norm_i(inc_norm), .inc_corr_i(inc_corr), .step_o(step)
  );

  ptp_tmr_count #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_count (
    .clk_i, .rst_ni,
    .run_i(run), .prst_i(prst), .evt_i(evt), .period_i(period),
    .step_i(step), .load_i(load), .load_val_i(load_val),
    .cnt_o(cnt), .wrap_pulse_o(wrap_pulse_o)
  );

  // R4: zero interval always adds the normal step
  assert_plain_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !load && !prst && corr_per == '0) |=>
      cnt == $past(cnt) + {{(CNT_W-STEP_W){1'b0}}, $past(inc_norm)});
endmodule

// File: tb/sim_ptp_ns_timer.sv
module sim_ptp_ns_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic pulse;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ptp_ns_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wrap_pulse_o(pulse)
  );

  localparam logic [2:0] CTRL = 3'd0, TMR = 3'd1, PER = 3'd2, CORR = 3'd3, INC = 3'd4;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic snap(output logic [31:0] v);
    wr(CTRL, 32'h800);
    rd(TMR, v);
  endtask

  // common setup while stopped: leaves ctrl=0, counter=start
  task automatic setup(logic [31:0] inc, logic [31:0] cper, logic [31:0] per, logic [31:0] start);
    wr(CTRL, 0); wr(INC, inc); wr(CORR, cper); wr(PER, per); wr(TMR, start);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(a[2:0], v); chk("R1 reg", v, 0);
    end
    chk("R1 pulse", {31'b0, pulse}, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(PER, 32'hDEADBEEF); rd(PER, v); chk("R10 period", v, 32'hDEADBEEF);
    wr(CORR, 32'hFFFFFFFF); rd(CORR, v); chk("R10 corr", v, 32'hFFFFFFFF);
    wr(INC, 32'hFFFFFFFF); rd(INC, v); chk("R10 inc", v, 32'h00007F7F);
    wr(CTRL, 32'hFFFFFFFF); rd(CTRL, v); chk("R10 ctrl (R8 bit11 reads 0)", v, 32'h000000B1);
    wr(CTRL, 0);
  endtask

  task automatic t_capture;
    logic [31:0] v;
    setup(3, 0, 0, 32'h1234);
    snap(v); chk("R9 load", v, 32'h1234);
    wr(TMR, 32'h5555); rd(TMR, v); chk("R8 capture stable", v, 32'h1234);
    snap(v); chk("R8 new capture", v, 32'h5555);
    rd(CTRL, v); chk("R8 self-clear", v, 0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    setup(3, 0, 0, 0);
    wr(CTRL, 1); idle(10); wr(CTRL, 0);
    snap(v); chk("R2 count 12 steps", v, 36);
    idle(5); snap(v); chk("R2 hold when stopped", v, 36);
    // load into a running counter: load edge then two increments
    setup(5, 0, 0, 0);
    wr(CTRL, 1); wr(TMR, 32'h1000); wr(CTRL, 0);
    snap(v); chk("R9 load over run", v, 32'h100A);
  endtask

  task automatic t_corr;
    logic [31:0] v;
    setup(32'h0705, 3, 0, 0);
    wr(CTRL, 1); idle(12); wr(CTRL, 0);
    snap(v); chk("R3 corr 14 steps", v, 14*5 + 3*2);
    wr(CTRL, 1); wr(CTRL, 0);
    snap(v); chk("R3 phase kept over pause", v, 76 + 5 + 7);
    setup(32'h0705, 0, 0, 0);
    wr(CTRL, 1); idle(6); wr(CTRL, 0);
    snap(v); chk("R4 no correction", v, 40);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    setup(7, 0, 100, 95);
    wr(CTRL, 32'hB1);
    @(negedge clk); chk("R7 pulse after wrap", {31'b0, pulse}, 1);
    @(negedge clk); chk("R7 pulse one cycle", {31'b0, pulse}, 0);
    wr(CTRL, 0);
    snap(v); chk("R5 wrapped value", v, 23);
    setup(7, 0, 100, 93);
    wr(CTRL, 32'hB1);
    @(negedge clk); chk("R5 exact period pulse", {31'b0, pulse}, 1);
    wr(CTRL, 0);
    snap(v); chk("R5 exact period value", v, 14);
    setup(7, 0, 100, 95);
    wr(CTRL, 32'h31);
    @(negedge clk); chk("R7 masked pulse", {31'b0, pulse}, 0);
    @(negedge clk); chk("R7 masked pulse", {31'b0, pulse}, 0);
    wr(CTRL, 0);
    snap(v); chk("R7 wrap still happens", v, 23);
    setup(7, 0, 100, 95);
    wr(CTRL, 32'h81);
    @(negedge clk); chk("R6 no pulse", {31'b0, pulse}, 0);
    @(negedge clk);
    wr(CTRL, 0);
    snap(v); chk("R6 period ignored", v, 123);
    setup(3, 0, 100, 32'hFFFFFFFE);
    wr(CTRL, 1); wr(CTRL, 0);
    snap(v); chk("R6 natural rollover", v, 4);
  endtask

  initial begin
    fork
      begin
        idle(3); rst_n = 1'b1; idle(2);
        t_reset(); t_regmap(); t_capture(); t_count(); t_corr(); t_wrap();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog actual=running expected=done");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule